// File: doc/BRIEF.md
# Accumulator-Link Operate Microinstruction Unit

This block is the combinational datapath that executes operate microinstructions for a 12-bit accumulator machine. It takes the current instruction word, the present accumulator and the one-bit link, and produces the accumulator and link values to write back, together with a flag telling the sequencer to skip the next instruction. Group-1 operate words clear, complement, increment and rotate the 13-bit link:accumulator pair. Group-2 operate words test the accumulator and raise the skip flag.

Several micro-operations can be encoded in one group-1 word. They are applied in a fixed order inside a single evaluation: clears, then complements, then the increment, then the rotation. Rotations move bits through the link as a thirteenth bit. A separate program-counter incrementer is provided beside the datapath. It wraps modulo 4096 and never reads or changes the link. Words that are not operate instructions leave the accumulator and link unchanged.

Top module: `acc_link_opunit`

## Requirements
- R1: In a group-1 word (bits 11:9 = 111, bit 8 = 0), bit 7 zeroes the accumulator and bit 6 zeroes the link. Both clears act before any other micro-operation.
- R2: In a group-1 word, bit 5 inverts the accumulator and bit 4 inverts the link, after the clears. Bits 7 and 5 together give 4095.
- R3: In a group-1 word, bit 0 adds one to the 13-bit link:accumulator pair after the complements. A carry out of the accumulator therefore inverts the link, and bits 5 and 0 together negate the accumulator.
- R4: In a group-1 word, bit 3 rotates right and bit 2 rotates left through the link, as the last step. Bit 1 makes the rotation two places instead of one.
- R5: A group-1 word with both bits 3 and 2 set, or with neither of them set, performs no rotation, whatever the value of bit 1.
- R6: A group-1 word never raises the skip flag.
- R7: In a group-2 word (bits 11:9 = 111, bit 8 = 1, bit 0 = 0), bit 6 tests for a set sign bit (bit 11) and bit 5 tests for a zero accumulator. The skip flag is the OR of the selected tests, inverted when bit 3 is set. This gives skip-on-nonzero (bits 5 and 3) and skip-on-minus (bit 6). The link is unchanged.
- R8: In a group-2 word, bit 7 zeroes the accumulator. The skip tests use the accumulator value from before the clear.
- R9: A word with bits 11:9 other than 111, or an operate word with bits 8 and 0 both set, passes the accumulator and link through unchanged with the skip flag low.
- R10: The program-counter output equals the program-counter input plus one, modulo 4096. It does not depend on the link or on the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_word | input | 12 | Instruction word being executed |
| ac_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| pc_in | input | 12 | Current program counter |
| ac_out | output | 12 | Accumulator value to write back |
| link_out | output | 1 | Link value to write back |
| skip | output | 1 | Skip the next instruction |
| pc_next | output | 12 | Incremented program counter |

## Verification
Single micro-operations are applied to accumulator values whose bits differ, so that each clear, complement and increment is seen on its own. Combined words for the constants 4095, 2048, 2047, 2 and 4094 show that the steps are applied in the fixed order and that rotations pass through the link. Increments on all-ones and on zero-after-complement accumulators show the carry into the link. Rotations by one and two places in each direction, the invalid direction combinations, and the skip tests on zero, one, 2047 and 2048 separate the direction, length and sense decoding. Non-operate words, and program-counter wrap with the link set, confirm that neither path affects the other.

// File: rtl/acc_link_opunit.sv
module acc_link_opunit #(
  parameter int DW = 12
) (
  input  logic [11:0]   op_word,
  input  logic [DW-1:0] ac_in,
  input  logic          link_in,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] ac_out,
  output logic          link_out,
  output logic          skip,
  output logic [DW-1:0] pc_next
);
  localparam int LW = DW + 1;

  logic is_opr, grp1, grp2;
  assign is_opr = (op_word[11:9] == 3'b111);
  assign grp1   = is_opr & ~op_word[8];
  assign grp2   = is_opr & op_word[8] & ~op_word[0];

  logic [LW-1:0] s_clr, s_cmp, s_inc, s_rot;
  assign s_clr = {link_in & ~op_word[6], ac_in & ~{DW{op_word[7]}}};
  assign s_cmp = s_clr ^ {op_word[4], {DW{op_word[5]}}};
  assign s_inc = s_cmp + LW'(op_word[0]);

  logic go_r, go_l;
  assign go_r = op_word[3] & ~op_word[2];
  assign go_l = op_word[2] & ~op_word[3];

  always_comb begin
    s_rot = s_inc;
    if (go_l)
      s_rot = op_word[1] ? {s_inc[LW-3:0], s_inc[LW-1:LW-2]}
                         : {s_inc[LW-2:0], s_inc[LW-1]};
    else if (go_r)
      s_rot = op_word[1] ? {s_inc[1:0], s_inc[LW-1:2]}
                         : {s_inc[0], s_inc[LW-1:1]};
  end

  logic tst_hit;
  assign tst_hit = (op_word[6] & ac_in[DW-1]) | (op_word[5] & (ac_in == '0));

  assign ac_out   = grp1 ? s_rot[DW-1:0] : (grp2 & op_word[7]) ? '0 : ac_in;
  assign link_out = grp1 ? s_rot[LW-1] : link_in;
  assign skip     = grp2 & (tst_hit ^ op_word[3]);
  assign pc_next  = pc_in + DW'(1);

  always_comb begin
    // R1
    if (grp1 && op_word[7] && !op_word[5] && !op_word[0] && op_word[3:2] == 2'b00)
      cla_zero_chk: assert (ac_out == '0);
    // R2
    if (grp1 && op_word[7] && op_word[5] && !op_word[0] && op_word[3:2] == 2'b00)
      cla_cma_ones_chk: assert (ac_out == '1);
    // R6
    if (grp1)
      grp1_noskip_chk: assert (!skip);
    // R7
    if (grp2)
      grp2_link_chk: assert (link_out == link_in);
    // R8
    if (grp2 && op_word[7])
      grp2_clear_chk: assert (ac_out == '0);
    // R9
    if (!is_opr)
      pass_through_chk: assert (ac_out == ac_in && link_out == link_in && !skip);
    // R10
    pc_step_chk: assert (pc_next != pc_in && (pc_in != '1 || pc_next == '0));
  end
endmodule

// File: tb/acc_link_opunit_tb.sv
module acc_link_opunit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] op_word, ac_in, pc_in, ac_out, pc_next;
  logic link_in, link_out, skip;
  int checks = 0, errors = 0;
  bit done = 0;

  acc_link_opunit u_dut (
    .op_word(op_word), .ac_in(ac_in), .link_in(link_in), .pc_in(pc_in),
    .ac_out(ac_out), .link_out(link_out), .skip(skip), .pc_next(pc_next)
  );

  task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %o expected %o", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [11:0] w, input logic [11:0] a, input logic l);
    @(negedge clk);
    op_word = w; ac_in = a; link_in = l;
    #5;
  endtask

  task automatic expect_al(input string tag, input logic [11:0] a, input logic l, input logic s);
    chk(tag, {link_out, ac_out}, {l, a});
    chk(tag, {12'd0, skip}, {12'd0, s});
  endtask

  task automatic t_idle;
    apply(12'o0000, 12'o0000, 1'b0);
    pc_in = 12'o0000; #1;
    expect_al("R9 idle", 12'o0000, 1'b0, 1'b0);
    chk("R10 idle", {1'b0, pc_next}, 13'o1);
  endtask

  task automatic t_clears;
    apply(12'o7200, 12'o5252, 1'b1); expect_al("R1 cla", 12'o0000, 1'b1, 1'b0);
    apply(12'o7100, 12'o5252, 1'b1); expect_al("R1 cll", 12'o5252, 1'b0, 1'b0);
  endtask

  task automatic t_complements;
    apply(12'o7240, 12'o1234, 1'b1); expect_al("R2 cla cma", 12'o7777, 1'b1, 1'b0);
    apply(12'o7060, 12'o1234, 1'b0); expect_al("R2 cma cml", 12'o6543, 1'b1, 1'b0);
  endtask

  task automatic t_increment;
    apply(12'o7001, 12'o7777, 1'b0); expect_al("R3 carry sets", 12'o0000, 1'b1, 1'b0);
    apply(12'o7001, 12'o7777, 1'b1); expect_al("R3 carry clears", 12'o0000, 1'b0, 1'b0);
    apply(12'o7041, 12'o0005, 1'b0); expect_al("R3 negate", 12'o7773, 1'b0, 1'b0);
    apply(12'o7041, 12'o0000, 1'b0); expect_al("R3 negate zero", 12'o0000, 1'b1, 1'b0);
    apply(12'o7241, 12'o1234, 1'b0); expect_al("R3 after clear", 12'o0000, 1'b1, 1'b0);
  endtask

  task automatic t_rotates;
    apply(12'o7330, 12'o1234, 1'b0); expect_al("R4 2048", 12'o4000, 1'b0, 1'b0);
    apply(12'o7350, 12'o1234, 1'b1); expect_al("R4 2047", 12'o3777, 1'b1, 1'b0);
    apply(12'o7326, 12'o1234, 1'b0); expect_al("R4 two", 12'o0002, 1'b0, 1'b0);
    apply(12'o7344, 12'o1234, 1'b0); expect_al("R4 4094", 12'o7776, 1'b1, 1'b0);
    apply(12'o7010, 12'o0001, 1'b0); expect_al("R4 rar", 12'o0000, 1'b1, 1'b0);
    apply(12'o7012, 12'o0001, 1'b0); expect_al("R4 rtr", 12'o4000, 1'b0, 1'b0);
    apply(12'o7005, 12'o3777, 1'b0); expect_al("R4 inc then ral", 12'o0000, 1'b1, 1'b0);
  endtask

  task automatic t_bad_rotate;
    apply(12'o7014, 12'o1234, 1'b1); expect_al("R5 both dirs", 12'o1234, 1'b1, 1'b0);
    apply(12'o7016, 12'o1234, 1'b0); expect_al("R5 both dirs twice", 12'o1234, 1'b0, 1'b0);
    apply(12'o7002, 12'o1234, 1'b1); expect_al("R5 twice only", 12'o1234, 1'b1, 1'b0);
  endtask

  task automatic t_grp1_skip;
    apply(12'o7000, 12'o0000, 1'b0); expect_al("R6 nop zero", 12'o0000, 1'b0, 1'b0);
    apply(12'o7100, 12'o4000, 1'b1); expect_al("R6 cll minus", 12'o4000, 1'b0, 1'b0);
  endtask

  task automatic t_skips;
    apply(12'o7450, 12'o0000, 1'b1); expect_al("R7 sna zero", 12'o0000, 1'b1, 1'b0);
    apply(12'o7450, 12'o0001, 1'b0); expect_al("R7 sna nonzero", 12'o0001, 1'b0, 1'b1);
    apply(12'o7500, 12'o4000, 1'b1); expect_al("R7 sma minus", 12'o4000, 1'b1, 1'b1);
    apply(12'o7500, 12'o3777, 1'b0); expect_al("R7 sma plus", 12'o3777, 1'b0, 1'b0);
    apply(12'o7510, 12'o3777, 1'b0); expect_al("R7 spa plus", 12'o3777, 1'b0, 1'b1);
    apply(12'o7410, 12'o1234, 1'b1); expect_al("R7 always", 12'o1234, 1'b1, 1'b1);
    apply(12'o7400, 12'o0000, 1'b0); expect_al("R7 no test", 12'o0000, 1'b0, 1'b0);
  endtask

  task automatic t_grp2_clear;
    apply(12'o7700, 12'o4000, 1'b1); expect_al("R8 sma cla", 12'o0000, 1'b1, 1'b1);
    apply(12'o7640, 12'o0000, 1'b0); expect_al("R8 sza cla", 12'o0000, 1'b0, 1'b1);
  endtask

  task automatic t_passthru;
    apply(12'o1234, 12'o5252, 1'b1); expect_al("R9 tad", 12'o5252, 1'b1, 1'b0);
    apply(12'o5200, 12'o0000, 1'b0); expect_al("R9 jmp", 12'o0000, 1'b0, 1'b0);
    apply(12'o7641, 12'o4000, 1'b1); expect_al("R9 bit0 grp", 12'o4000, 1'b1, 1'b0);
  endtask

  task automatic t_pc;
    apply(12'o7001, 12'o7777, 1'b1);
    pc_in = 12'o7777; #1;
    chk("R10 wrap", {1'b0, pc_next}, 13'o0);
    chk("R10 link kept", {link_out, 12'o0}, {1'b0, 12'o0});
    apply(12'o7120, 12'o0000, 1'b1);
    pc_in = 12'o0123; #1;
    chk("R10 step", {1'b0, pc_next}, 13'o0124);
  endtask

  initial begin
    op_word = '0; ac_in = '0; link_in = 1'b0; pc_in = '0;
    t_idle;
    t_clears;
    t_complements;
    t_increment;
    t_rotates;
    t_bad_rotate;
    t_grp1_skip;
    t_skips;
    t_grp2_clear;
    t_passthru;
    t_pc;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule